// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This unit divides every CAN bit into time quanta and follows the receive line so that the protocol sequencer gets a cleanly sampled bit value together with two timing strobes. One strobe marks the sample point. The other marks the start of each bit, which is the moment to drive the next transmit bit. The length of a quantum comes from a clock prescaler. The bit is built from a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. The sample point is the boundary between the two phase segments.

The unit corrects its bit phase on falling (recessive-to-dominant) edges of the receive line. When the sequencer signals that a start of frame is expected, such an edge restarts the bit at once (hard synchronization). At other times the unit resynchronizes. A late edge lengthens phase segment 1 and an early edge shortens phase segment 2, and the correction is capped by a programmable jump width. Resynchronization is held off while the node itself drives a dominant bit. At most one phase correction happens between two sample points. An optional mode takes three samples on consecutive quanta and decides the bit value by majority.

The receive line is expected to be synchronous to `clk`. Configuration fields hold the length minus one.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2 × (cfg_brp + 1) clock cycles. With no falling edge on the line, consecutive tx_strobe pulses are (1 + prop + ph1 + ph2) quanta apart. The segment lengths are the field value plus one (cfg_prop, cfg_ph1: 1..8; cfg_ph2: 2..8, where field value 0 is taken as 2).
- R2: tx_strobe pulses for one cycle at the start of each sync segment. sample_strobe pulses for one cycle (1 + prop + ph1) quanta after it, at the end of phase segment 1.
- R3: While sof_expect is 1, a falling edge seen at a quantum boundary restarts the bit. tx_strobe pulses in the cycle after that boundary, and the next sample point follows the nominal distance from it.
- R4: A falling edge seen while the quantum being entered lies inside phase segment 1 or the propagation segment is late by (position + 1) quanta. The current phase segment 1 is then lengthened by min(error, sjw), where sjw = cfg_sjw + 1.
- R5: A falling edge seen while the quantum being entered lies in phase segment 2 is early by the number of quanta left in that segment. Phase segment 2 is then shortened by min(error, sjw).
- R6: When sof_expect is 0 and tx_dominant is 1, falling edges cause no resynchronization.
- R7: After one hard synchronization or resynchronization, further falling edges have no effect until the next sample point.
- R8: With cfg_triple = 1, rx_bit takes the majority of the line values at the three quantum boundaries ending at the sample point. With cfg_triple = 0 it takes the value at the sample-point boundary alone. rx_bit changes only together with sample_strobe.
- R9: While rst is 1, and in the first cycle after it, tx_strobe and sample_strobe are 0 and rx_bit is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Receive line level (1 = recessive) |
| sof_expect | input | 1 | Start of frame expected; falling edges hard-synchronize |
| tx_dominant | input | 1 | Node is currently driving a dominant bit |
| cfg_brp | input | BRP_W | Prescaler; quantum = 2 × (cfg_brp + 1) clocks |
| cfg_prop | input | 3 | Propagation segment length minus one |
| cfg_ph1 | input | 3 | Phase segment 1 length minus one |
| cfg_ph2 | input | 3 | Phase segment 2 length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| cfg_triple | input | 1 | Three-sample majority mode |
| rx_bit | output | 1 | Sampled bit value |
| sample_strobe | output | 1 | One-cycle pulse at the sample point |
| tx_strobe | output | 1 | One-cycle pulse at the start of each bit |

## Verification
The bench keeps the default BRP_W = 6 and drives cfg_brp with the values 0, 1 and 3. The smallest quantum of two clocks lets every directed case place an edge on an exact quantum boundary, and the larger values show that the quantum scales the whole bit. The segment settings run from the shortest bit of five quanta to the longest of twenty-five. The directed cases use prop 2, ph1 3 and ph2 3, which leave room for late errors of one to three quanta and early errors of one or two, so each can be measured against jump widths of 1, 2 and 4.

// File: rtl/cbtim_pkg.sv
package cbtim_pkg;

    localparam int SEG_W = 3;
    localparam int SJW_W = 2;
    localparam int LEN_W = 5;

    typedef logic [LEN_W-1:0] qlen_t;

    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_TSEG1 = 2'd1,
        SEG_TSEG2 = 2'd2
    } seg_e;

    typedef struct packed {
        seg_e  seg;
        qlen_t idx;
    } qpos_t;

    typedef struct packed {
        logic [SEG_W-1:0] prop_m1;
        logic [SEG_W-1:0] ph1_m1;
        logic [SEG_W-1:0] ph2_m1;
        logic [SJW_W-1:0] sjw_m1;
    } tseg_cfg_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic qlen_t qmin(input qlen_t a, input qlen_t b);
        return (a < b) ? a : b;
    endfunction

    // propagation plus phase 1, both stored as length minus one
    function automatic qlen_t tseg1_len(input tseg_cfg_t c);
        return qlen_t'(c.prop_m1) + qlen_t'(c.ph1_m1) + qlen_t'(2);
    endfunction

    function automatic qlen_t tseg2_len(input tseg_cfg_t c);
        return (c.ph2_m1 == '0) ? qlen_t'(2) : qlen_t'(c.ph2_m1) + qlen_t'(1);
    endfunction

    function automatic qlen_t jump_len(input tseg_cfg_t c);
        return qlen_t'(c.sjw_m1) + qlen_t'(1);
    endfunction

endpackage

// File: rtl/cbtim_prescaler.sv
module cbtim_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_tick
);
    localparam int CNT_W = BRP_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // quantum = 2*(brp+1) clocks, so the final count is 2*brp+1
    assign last    = {brp, 1'b1};
    assign tq_tick = (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (tq_tick) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cbtim_sampler.sv
module cbtim_sampler
    import cbtim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tq_tick,
    input  logic rx_line,
    input  logic triple,
    output logic fall_seen,
    output logic voted
);
    // line values at the two previous quantum boundaries, newest in bit 0
    logic [1:0] hist;

    always_ff @(posedge clk) begin
        if (rst)          hist <= 2'b11;
        else if (tq_tick) hist <= {hist[0], rx_line};
    end

    assign fall_seen = tq_tick & hist[0] & ~rx_line;
    assign voted     = triple ? vote3({hist, rx_line}) : rx_line;
endmodule

// File: rtl/cbtim_bit_fsm.sv
module cbtim_bit_fsm
    import cbtim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tq_tick,
    input  logic      fall_seen,
    input  logic      sof_expect,
    input  logic      tx_dominant,
    input  tseg_cfg_t cfg,
    output logic      sample_evt,
    output logic      sync_evt
);
    qpos_t pos, nom, nxt;
    qlen_t t1_len, t1_nom, t2_len, sjw, late_err, early_err, t1_next;
    logic  synced, hard, resync, last_t1, last_t2;

    always_comb begin
        t1_nom  = tseg1_len(cfg);
        t2_len  = tseg2_len(cfg);
        sjw     = jump_len(cfg);
        last_t1 = (pos.idx >= t1_len - qlen_t'(1));
        last_t2 = (pos.idx >= t2_len - qlen_t'(1));

        // nominal successor of the current quantum
        case (pos.seg)
            SEG_SYNC:  nom = '{seg: SEG_TSEG1, idx: '0};
            SEG_TSEG1: nom = last_t1 ? '{seg: SEG_TSEG2, idx: '0}
                                     : '{seg: SEG_TSEG1, idx: pos.idx + qlen_t'(1)};
            SEG_TSEG2: nom = last_t2 ? '{seg: SEG_SYNC, idx: '0}
                                     : '{seg: SEG_TSEG2, idx: pos.idx + qlen_t'(1)};
            default:   nom = '{seg: SEG_SYNC, idx: '0};
        endcase

        // phase error of an edge belonging to the quantum being entered
        late_err  = nom.idx + qlen_t'(1);
        early_err = t2_len - nom.idx;

        hard   = fall_seen & ~synced & sof_expect;
        resync = fall_seen & ~synced & ~sof_expect & ~tx_dominant & (nom.seg != SEG_SYNC);

        nxt     = nom;
        t1_next = t1_len;
        if (hard) begin
            nxt     = '{seg: SEG_SYNC, idx: '0};
            t1_next = t1_nom;
        end else if (resync) begin
            if (nom.seg == SEG_TSEG1) begin
                t1_next = t1_len + qmin(late_err, sjw);
            end else if (early_err <= sjw) begin
                nxt = '{seg: SEG_SYNC, idx: '0};
            end else begin
                nxt = '{seg: SEG_TSEG2, idx: nom.idx + sjw};
            end
        end

        sample_evt = tq_tick & (pos.seg == SEG_TSEG1) & last_t1 & ~hard;
        if (sample_evt) t1_next = t1_nom;
        sync_evt = tq_tick & (nxt.seg == SEG_SYNC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '{seg: SEG_SYNC, idx: '0};
            t1_len <= tseg1_len(cfg);
            synced <= 1'b0;
        end else if (tq_tick) begin
            pos    <= nxt;
            t1_len <= t1_next;
            if (hard | resync)   synced <= 1'b1;
            else if (sample_evt) synced <= 1'b0;
        end
    end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import cbtim_pkg::*;
#(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic             sof_expect,
    input  logic             tx_dominant,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [2:0]       cfg_prop,
    input  logic [2:0]       cfg_ph1,
    input  logic [2:0]       cfg_ph2,
    input  logic [1:0]       cfg_sjw,
    input  logic             cfg_triple,
    output logic             rx_bit,
    output logic             sample_strobe,
    output logic             tx_strobe
);
    tseg_cfg_t tcfg;
    logic      tq_tick, fall_seen, voted, sample_evt, sync_evt;

    assign tcfg = '{prop_m1: cfg_prop, ph1_m1: cfg_ph1, ph2_m1: cfg_ph2, sjw_m1: cfg_sjw};

    cbtim_prescaler #(.BRP_W(BRP_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .brp     (cfg_brp),
        .tq_tick (tq_tick)
    );

    cbtim_sampler u_samp (
        .clk       (clk),
        .rst       (rst),
        .tq_tick   (tq_tick),
        .rx_line   (rx_line),
        .triple    (cfg_triple),
        .fall_seen (fall_seen),
        .voted     (voted)
    );

    cbtim_bit_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tq_tick     (tq_tick),
        .fall_seen   (fall_seen),
        .sof_expect  (sof_expect),
        .tx_dominant (tx_dominant),
        .cfg         (tcfg),
        .sample_evt  (sample_evt),
        .sync_evt    (sync_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_bit        <= 1'b1;
            sample_strobe <= 1'b0;
            tx_strobe     <= 1'b0;
        end else begin
            sample_strobe <= sample_evt;
            tx_strobe     <= sync_evt;
            if (sample_evt) rx_bit <= voted;
        end
    end
endmodule

// File: rtl/cbtim_checker.sv
module cbtim_checker (
    input logic clk,
    input logic rst,
    input logic tq_tick,
    input logic rx_bit,
    input logic sample_strobe,
    input logic tx_strobe
);
    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (!sample_strobe && !tx_strobe && rx_bit));

    assert_sample_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe);

    assert_tx_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        tx_strobe |=> !tx_strobe);

    assert_quantum_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe || tx_strobe) |-> $past(tq_tick));

    assert_rxbit_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !sample_strobe |-> $stable(rx_bit));
endmodule

bind can_bit_timing cbtim_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .tq_tick       (tq_tick),
    .rx_bit        (rx_bit),
    .sample_strobe (sample_strobe),
    .tx_strobe     (tx_strobe)
);

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb_top;
    localparam int BRP_W = 6;

    // brp, prop, ph1, ph2 (real lengths), tx->sample clocks, tx->tx clocks
    localparam int VEC [4][6] = '{
        '{0, 1, 1, 2,  6, 10},
        '{1, 2, 3, 3, 24, 36},
        '{0, 8, 8, 8, 34, 50},
        '{3, 1, 2, 4, 32, 64}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic rx = 1'b1, sofx = 1'b0, txd = 1'b0, triple = 1'b0;
    logic [BRP_W-1:0] brp = '0;
    logic [2:0] prop = 3'd1, ph1 = 3'd2, ph2 = 3'd2;
    logic [1:0] sjw = 2'd0;
    logic rx_bit, smp, txs;
    int cyc = 0, n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timing #(.BRP_W(BRP_W)) dut_i (
        .clk (clk), .rst (rst), .rx_line (rx), .sof_expect (sofx),
        .tx_dominant (txd), .cfg_brp (brp), .cfg_prop (prop), .cfg_ph1 (ph1),
        .cfg_ph2 (ph2), .cfg_sjw (sjw), .cfg_triple (triple),
        .rx_bit (rx_bit), .sample_strobe (smp), .tx_strobe (txs)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tx(output int t);
        @(negedge clk);
        while (!txs) @(negedge clk);
        t = cyc;
    endtask

    task automatic wait_smp(output int t, output logic b);
        @(negedge clk);
        while (!smp) @(negedge clk);
        t = cyc;
        b = rx_bit;
    endtask

    task automatic settle();
        int t;
        repeat (3) wait_tx(t);
    endtask

    task automatic set_cfg(input int b, input int p, input int a, input int c);
        brp  = BRP_W'(b);
        prop = 3'(p - 1);
        ph1  = 3'(a - 1);
        ph2  = 3'(c - 1);
    endtask

    initial begin
        int t0, t1, ts;
        logic b;
        set_cfg(0, 2, 3, 3);
        repeat (3) @(negedge clk);
        check("R9 sample_strobe in reset", int'(smp), 0);
        check("R9 tx_strobe in reset", int'(txs), 0);
        check("R9 rx_bit in reset", int'(rx_bit), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R9 tx_strobe after reset", int'(txs), 0);

        // R1 / R2: nominal bit shapes from the table
        for (int i = 0; i < 4; i++) begin
            set_cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
            settle();
            wait_tx(t0);
            wait_smp(ts, b);
            wait_tx(t1);
            check($sformatf("R2 vector %0d tx->sample", i), ts - t0, VEC[i][4]);
            check($sformatf("R1 vector %0d bit period", i), t1 - t0, VEC[i][5]);
        end

        // directed cases: quantum 2 clocks, prop 2, ph1 3, ph2 3
        set_cfg(0, 2, 3, 3);
        settle();

        // R3 hard sync
        sofx = 1'b1;
        wait_tx(t0);
        repeat (4) @(negedge clk);
        rx = 1'b0;
        wait_tx(t1);
        check("R3 hard sync restart", t1 - t0, 6);
        wait_smp(ts, b);
        check("R3 sample after hard sync", ts - t1, 12);
        check("R3 sampled dominant", int'(b), 0);
        rx = 1'b1; sofx = 1'b0;
        settle();

        // R4 late edge, error 2, sjw 1 and sjw 4
        sjw = 2'd0;
        settle();
        wait_tx(t0);
        fork
            begin repeat (2) @(negedge clk); rx = 1'b0; end
            wait_smp(ts, b);
        join
        check("R4 late edge clipped to sjw 1", ts - t0, 14);
        rx = 1'b1; sjw = 2'd3;
        settle();
        wait_tx(t0);
        fork
            begin repeat (2) @(negedge clk); rx = 1'b0; end
            wait_smp(ts, b);
        join
        check("R4 late edge full error 2", ts - t0, 16);
        rx = 1'b1;
        settle();

        // R7 second edge before the sample point is ignored
        wait_tx(t0);
        fork
            begin
                rx = 1'b0;
                repeat (2) @(negedge clk); rx = 1'b1;
                repeat (2) @(negedge clk); rx = 1'b0;
            end
            wait_smp(ts, b);
        join
        check("R7 only first edge resyncs", ts - t0, 14);
        rx = 1'b1;
        settle();

        // R5 early edge, error 2, sjw 1 and sjw 2
        sjw = 2'd0;
        settle();
        wait_tx(t0);
        fork
            begin repeat (12) @(negedge clk); rx = 1'b0; end
            begin wait_smp(ts, b); wait_tx(t1); end
        join
        check("R5 early edge clipped to sjw 1", t1 - t0, 16);
        check("R5 sample before early edge", int'(b), 1);
        rx = 1'b1; sjw = 2'd1;
        settle();
        wait_tx(t0);
        fork
            begin repeat (12) @(negedge clk); rx = 1'b0; end
            begin wait_smp(ts, b); wait_tx(t1); end
        join
        check("R5 early edge full error 2", t1 - t0, 14);
        rx = 1'b1;
        settle();

        // R6 no resync while sending dominant
        sjw = 2'd3; txd = 1'b1;
        settle();
        wait_tx(t0);
        fork
            begin repeat (2) @(negedge clk); rx = 1'b0; end
            wait_smp(ts, b);
        join
        check("R6 edge ignored while dominant", ts - t0, 12);
        rx = 1'b1;
        settle();

        // R8 majority voting (resync held off by txd)
        triple = 1'b1;
        settle();
        wait_tx(t0);
        fork
            begin repeat (10) @(negedge clk); rx = 1'b0; repeat (2) @(negedge clk); rx = 1'b1; end
            wait_smp(ts, b);
        join
        check("R8 triple mode outvotes one low sample", int'(b), 1);
        settle();
        triple = 1'b0;
        settle();
        wait_tx(t0);
        fork
            begin repeat (10) @(negedge clk); rx = 1'b0; repeat (2) @(negedge clk); rx = 1'b1; end
            wait_smp(ts, b);
        join
        check("R8 single mode takes last sample", int'(b), 0);
        settle();
        triple = 1'b1;
        settle();
        wait_tx(t0);
        fork
            begin repeat (8) @(negedge clk); rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1; end
            wait_smp(ts, b);
        join
        check("R8 triple mode two low samples", int'(b), 0);
        txd = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule